// File: doc/BRIEF.md
# Reorder-Buffer Head Commit Decision Unit

This block sits at the retire end of an out-of-order core. Each cycle it looks at a small window of entries at the head of the reorder buffer for one thread. The thread has already been chosen elsewhere. The unit decides which of those entries retire, up to a fixed number of commit slots. It also decides whether a serializing instruction or an uncached load is released for execution, and whether a faulting head raises a trap. It reports why the walk stopped when it stops early.

For each thread the unit keeps a program-counter triple that moves forward with every retirement. It keeps a trap-pending hold until the trap is acknowledged. It sends two kinds of reports back to the earlier pipeline stages: a free-entry update whenever the thread's occupancy changed, and an empty report once per emptying event. The empty report is never sent in a cycle that committed a store. A saturating counter records the cycles that used every commit slot. The reorder-buffer storage and the thread choice are outside this block. All results are registered and appear one cycle after the inputs that caused them.

Top module: `commit_head_unit`

## Requirements
- R1: The head window is walked from index 0 upward. Entries retire as a prefix of the window, and retireVec bit i marks entry i. The walk stops at the first entry that is not valid or not ready, and then stallCode=1. When the walk consumes the whole window, or ends on a release or trap action, stallCode=0. With selValid low nothing retires and stallCode=0. Stall codes: 0 none, 1 head not ready, 2 serialize wait, 3 fault wait, 4 trap hold.
- R2: A squashed ready entry retires without taking a commit slot. It is not counted, and it does not stop a later serializing or faulting entry from using the first slot.
- R3: An unexecuted entry marked serializing is never retired. It is released only when no non-squashed entry retired before it in the same cycle and storesPending is low. A release drives relValid with that entry's sequence number and relUncached=0. Otherwise stallCode=2.
- R4: An unexecuted load follows the same rule as R3. Its release additionally raises relUncached=1. If an entry is marked both serializing and load, it is treated as serializing.
- R5: An executed entry with a fault is never retired. It raises trapReq for the selected thread only under the R3 condition, and then the thread becomes trap-pending. Otherwise stallCode=3.
- R6: While the selected thread is trap-pending, nothing retires and stallCode=4. trapAck for the thread clears the hold at the end of that cycle.
- R7: Each non-squashed retirement moves the thread's counter triple forward: current takes next, next takes next-next, and next-next grows by INST_BYTES. After reset the current value is 0, so pcOut equals the number of non-squashed retirements times INST_BYTES.
- R8: commitCnt counts the retired entries that are neither squashed nor nops/prefetches. Nops still use a slot.
- R9: storeFlag for a thread is high for exactly the one cycle after a cycle in which one of its stores retired.
- R10: emptyRpt for a thread fires once per arming. A thread is armed by an occupancy change, and the report needs robEmpty high, storesPending low and no store retired by that thread in the same cycle.
- R11: freeUpd for a thread is high when occChanged was high for it, or when any entry of it retired.
- R12: fullCnt counts the cycles in which every commit slot was used, and it saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| selValid | input | 1 | a thread is selected this cycle |
| selTid | input | TID_W | selected thread |
| headValid | input | W | window entry present |
| headReady | input | W | window entry may be examined |
| headSquashed | input | W | entry was squashed |
| headExecuted | input | W | entry finished execution |
| headSerial | input | W | non-speculative, store-conditional or barrier |
| headLoad | input | W | entry is a load |
| headStore | input | W | entry is a store |
| headFault | input | W | entry carries a fault |
| headNop | input | W | nop or instruction prefetch |
| headSeq | input | W*SEQ_W | sequence numbers, entry i at bits i*SEQ_W |
| storesPending | input | 1 | stores still await writeback |
| occChanged | input | THREADS | occupancy changed by other sources |
| robEmpty | input | THREADS | thread's buffer currently empty |
| trapAck | input | THREADS | trap handled, drop hold |
| retireVec | output | W | entries retired last cycle |
| retireTid | output | TID_W | thread of retireVec |
| commitCnt | output | CNT_W | counted commits last cycle |
| stallCode | output | 3 | stop reason |
| relValid | output | 1 | release issued |
| relUncached | output | 1 | release is an uncached load |
| relSeq | output | SEQ_W | released sequence number |
| trapReq | output | THREADS | trap request |
| freeUpd | output | THREADS | free-entry update strobe |
| emptyRpt | output | THREADS | empty report |
| storeFlag | output | THREADS | store committed previous cycle |
| pcOut | output | THREADS*PC_W | current counter per thread |
| fullCnt | output | FULLCNT_W | full-width cycle count |

## Verification
Every output is registered. The result of the inputs driven before a rising edge is therefore due just after that edge. The bench drives on the falling edge and samples one time unit after the next rising edge. A trap raised by one step blocks the step that follows. The bench therefore runs an extra hold cycle after each expected trap, with the acknowledge driven in that cycle. Empty reports depend on the arming history, so they are checked in a directed sequence that starts from a fresh reset.

// File: rtl/commit_pkg.sv
package commit_pkg;
  typedef enum logic [2:0] {
    STALL_NONE   = 3'd0,
    STALL_HEAD   = 3'd1,
    STALL_SERIAL = 3'd2,
    STALL_FAULT  = 3'd3,
    STALL_TRAP   = 3'd4
  } stall_e;

  typedef struct packed {
    logic   relGo;
    logic   uncached;
    logic   trapGo;
    logic   storeRetired;
    stall_e stall;
  } strobe_t;
endpackage

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int W = 4,
  parameter int SEQ_W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic               selValid,
  input  logic               trapHold,
  input  logic               storesPending,
  input  logic [W-1:0]       headValid,
  input  logic [W-1:0]       headReady,
  input  logic [W-1:0]       headSquashed,
  input  logic [W-1:0]       headExecuted,
  input  logic [W-1:0]       headSerial,
  input  logic [W-1:0]       headLoad,
  input  logic [W-1:0]       headStore,
  input  logic [W-1:0]       headFault,
  input  logic [W-1:0]       headNop,
  input  logic [W*SEQ_W-1:0] headSeq,
  output logic [W-1:0]       retireMask,
  output logic [CNT_W-1:0]   usedCnt,
  output logic [CNT_W-1:0]   countCnt,
  output logic [SEQ_W-1:0]   relSeq,
  output strobe_t            strb
);
  always_comb begin : walk
    logic alive;
    logic [CNT_W-1:0] used;
    logic [CNT_W-1:0] counted;
    retireMask = '0;
    relSeq     = '0;
    strb       = '0;
    strb.stall = STALL_NONE;
    used       = '0;
    counted    = '0;
    alive      = selValid;
    if (selValid && trapHold) begin
      alive      = 1'b0;
      strb.stall = STALL_TRAP;
    end
    for (int j = 0; j < W; j++) begin
      if (alive) begin
        if (!headValid[j] || !headReady[j]) begin
          alive      = 1'b0;
          strb.stall = STALL_HEAD;
        end else if (headSquashed[j]) begin
          retireMask[j] = 1'b1;
        end else if (!headExecuted[j]) begin
          alive = 1'b0;
          if (headSerial[j] || headLoad[j]) begin
            if (used == '0 && !storesPending) begin
              strb.relGo    = 1'b1;
              strb.uncached = headLoad[j] && !headSerial[j];
              relSeq        = headSeq[j*SEQ_W +: SEQ_W];
            end else begin
              strb.stall = STALL_SERIAL;
            end
          end else begin
            strb.stall = STALL_HEAD;
          end
        end else if (headFault[j]) begin
          alive = 1'b0;
          if (used == '0 && !storesPending) strb.trapGo = 1'b1;
          else strb.stall = STALL_FAULT;
        end else begin
          retireMask[j] = 1'b1;
          used = used + 1'b1;
          if (!headNop[j]) counted = counted + 1'b1;
          if (headStore[j]) strb.storeRetired = 1'b1;
        end
      end
    end
    usedCnt  = used;
    countCnt = counted;
  end
endmodule

// File: rtl/commit_dp.sv
module commit_dp
  import commit_pkg::*;
#(
  parameter int W = 4,
  parameter int THREADS = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W = 32,
  parameter int INST_BYTES = 4,
  parameter int FULLCNT_W = 8,
  localparam int CNT_W = $clog2(W + 1),
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    selValid,
  input  logic [TID_W-1:0]        selTid,
  input  logic                    storesPending,
  input  logic [THREADS-1:0]      occChanged,
  input  logic [THREADS-1:0]      robEmpty,
  input  logic [THREADS-1:0]      trapAck,
  input  logic [W-1:0]            retireMask,
  input  logic [CNT_W-1:0]        usedCnt,
  input  logic [CNT_W-1:0]        countCnt,
  input  logic [SEQ_W-1:0]        relSeqIn,
  input  strobe_t                 strb,
  output logic [W-1:0]            retireVec,
  output logic [TID_W-1:0]        retireTid,
  output logic [CNT_W-1:0]        commitCnt,
  output logic [2:0]              stallCode,
  output logic                    relValid,
  output logic                    relUncached,
  output logic [SEQ_W-1:0]        relSeq,
  output logic [THREADS-1:0]      trapReq,
  output logic [THREADS-1:0]      freeUpd,
  output logic [THREADS-1:0]      emptyRpt,
  output logic [THREADS-1:0]      storeFlag,
  output logic [THREADS*PC_W-1:0] pcOut,
  output logic [FULLCNT_W-1:0]    fullCnt,
  output logic [THREADS-1:0]      trapPend
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retireVec   <= '0;
      retireTid   <= '0;
      commitCnt   <= '0;
      stallCode   <= '0;
      relValid    <= 1'b0;
      relUncached <= 1'b0;
      relSeq      <= '0;
      fullCnt     <= '0;
    end else begin
      retireVec   <= retireMask;
      retireTid   <= selTid;
      commitCnt   <= countCnt;
      stallCode   <= strb.stall;
      relValid    <= strb.relGo;
      relUncached <= strb.relGo && strb.uncached;
      relSeq      <= strb.relGo ? relSeqIn : '0;
      if (usedCnt == CNT_W'(W) && fullCnt != '1) fullCnt <= fullCnt + 1'b1;
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic hit, anyRet, storeNow, armedN, rpt;
    logic armedQ, pendQ, trapQ, freeQ, rptQ, storeQ;
    logic [PC_W-1:0] pc, npc, nnpc, pcN, npcN, nnpcN;

    assign hit      = selValid && (selTid == TID_W'(t));
    assign anyRet   = hit && (retireMask != '0);
    assign storeNow = hit && strb.storeRetired;
    assign armedN   = armedQ || occChanged[t] || anyRet;
    assign rpt      = armedN && robEmpty[t] && !storesPending && !storeNow;

    always_comb begin
      pcN   = pc;
      npcN  = npc;
      nnpcN = nnpc;
      if (hit) begin
        for (int s = 0; s < W; s++) begin
          if (CNT_W'(s) < usedCnt) begin
            pcN   = npcN;
            npcN  = nnpcN;
            nnpcN = nnpcN + STEP;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armedQ <= 1'b0;
        pendQ  <= 1'b0;
        trapQ  <= 1'b0;
        freeQ  <= 1'b0;
        rptQ   <= 1'b0;
        storeQ <= 1'b0;
        pc     <= '0;
        npc    <= STEP;
        nnpc   <= STEP + STEP;
      end else begin
        armedQ <= armedN && !rpt;
        pendQ  <= (pendQ && !trapAck[t]) || (hit && strb.trapGo);
        trapQ  <= hit && strb.trapGo;
        freeQ  <= occChanged[t] || anyRet;
        rptQ   <= rpt;
        storeQ <= storeNow;
        pc     <= pcN;
        npc    <= npcN;
        nnpc   <= nnpcN;
      end
    end

    assign trapReq[t]   = trapQ;
    assign freeUpd[t]   = freeQ;
    assign emptyRpt[t]  = rptQ;
    assign storeFlag[t] = storeQ;
    assign trapPend[t]  = pendQ;
    assign pcOut[t*PC_W +: PC_W] = pc;
  end
endmodule

// File: rtl/commit_head_unit.sv
module commit_head_unit
  import commit_pkg::*;
#(
  parameter int W = 4,
  parameter int THREADS = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W = 32,
  parameter int INST_BYTES = 4,
  parameter int FULLCNT_W = 8,
  localparam int CNT_W = $clog2(W + 1),
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    selValid,
  input  logic [TID_W-1:0]        selTid,
  input  logic [W-1:0]            headValid,
  input  logic [W-1:0]            headReady,
  input  logic [W-1:0]            headSquashed,
  input  logic [W-1:0]            headExecuted,
  input  logic [W-1:0]            headSerial,
  input  logic [W-1:0]            headLoad,
  input  logic [W-1:0]            headStore,
  input  logic [W-1:0]            headFault,
  input  logic [W-1:0]            headNop,
  input  logic [W*SEQ_W-1:0]      headSeq,
  input  logic                    storesPending,
  input  logic [THREADS-1:0]      occChanged,
  input  logic [THREADS-1:0]      robEmpty,
  input  logic [THREADS-1:0]      trapAck,
  output logic [W-1:0]            retireVec,
  output logic [TID_W-1:0]        retireTid,
  output logic [CNT_W-1:0]        commitCnt,
  output logic [2:0]              stallCode,
  output logic                    relValid,
  output logic                    relUncached,
  output logic [SEQ_W-1:0]        relSeq,
  output logic [THREADS-1:0]      trapReq,
  output logic [THREADS-1:0]      freeUpd,
  output logic [THREADS-1:0]      emptyRpt,
  output logic [THREADS-1:0]      storeFlag,
  output logic [THREADS*PC_W-1:0] pcOut,
  output logic [FULLCNT_W-1:0]    fullCnt
);
  logic [W-1:0]       retireMask;
  logic [CNT_W-1:0]   usedCnt, countCnt;
  logic [SEQ_W-1:0]   relSeqC;
  logic [THREADS-1:0] trapPend;
  strobe_t            strb;

  commit_ctrl #(.W(W), .SEQ_W(SEQ_W)) u_ctrl (
    .selValid(selValid), .trapHold(trapPend[selTid]), .storesPending(storesPending),
    .headValid(headValid), .headReady(headReady), .headSquashed(headSquashed),
    .headExecuted(headExecuted), .headSerial(headSerial), .headLoad(headLoad),
    .headStore(headStore), .headFault(headFault), .headNop(headNop), .headSeq(headSeq),
    .retireMask(retireMask), .usedCnt(usedCnt), .countCnt(countCnt),
    .relSeq(relSeqC), .strb(strb)
  );

  commit_dp #(.W(W), .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W),
              .INST_BYTES(INST_BYTES), .FULLCNT_W(FULLCNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .selValid(selValid), .selTid(selTid),
    .storesPending(storesPending), .occChanged(occChanged), .robEmpty(robEmpty),
    .trapAck(trapAck), .retireMask(retireMask), .usedCnt(usedCnt), .countCnt(countCnt),
    .relSeqIn(relSeqC), .strb(strb), .retireVec(retireVec), .retireTid(retireTid),
    .commitCnt(commitCnt), .stallCode(stallCode), .relValid(relValid),
    .relUncached(relUncached), .relSeq(relSeq), .trapReq(trapReq), .freeUpd(freeUpd),
    .emptyRpt(emptyRpt), .storeFlag(storeFlag), .pcOut(pcOut), .fullCnt(fullCnt),
    .trapPend(trapPend)
  );
endmodule

// File: rtl/commit_head_chk.sv
module commit_head_chk #(
  parameter int W = 4,
  parameter int THREADS = 2,
  parameter int SEQ_W = 16,
  parameter int FULLCNT_W = 8,
  localparam int CNT_W = $clog2(W + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [W-1:0]         retireVec,
  input logic [CNT_W-1:0]     commitCnt,
  input logic [2:0]           stallCode,
  input logic                 relValid,
  input logic [THREADS-1:0]   trapReq,
  input logic [THREADS-1:0]   emptyRpt,
  input logic [THREADS-1:0]   storeFlag,
  input logic [FULLCNT_W-1:0] fullCnt
);
  // R1
  prefix_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retireVec & (retireVec + 1'b1)) == '0);
  // R5
  trap_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trapReq));
  // R3
  release_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> (trapReq == '0 && stallCode == 3'd0));
  // R6
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallCode == 3'd4 |-> (retireVec == '0 && commitCnt == '0));
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(commitCnt) <= $countones(retireVec));
  // R10
  empty_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emptyRpt & storeFlag) == '0);
  // R12
  full_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullCnt == $past(fullCnt)) || (fullCnt == $past(fullCnt) + 1'b1));
endmodule

bind commit_head_unit commit_head_chk #(
  .W(W), .THREADS(THREADS), .SEQ_W(SEQ_W), .FULLCNT_W(FULLCNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .retireVec(retireVec), .commitCnt(commitCnt),
  .stallCode(stallCode), .relValid(relValid), .trapReq(trapReq),
  .emptyRpt(emptyRpt), .storeFlag(storeFlag), .fullCnt(fullCnt)
);

// File: tb/commit_head_unit_test.sv
module commit_head_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 3;
  localparam int T = 2;
  localparam int SEQ_W = 8;
  localparam int PC_W = 16;
  localparam int IB = 4;
  localparam int FW = 4;
  localparam int CNT_W = $clog2(W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selValid = 1'b0;
  logic [0:0] selTid = '0;
  logic [W-1:0] headValid = '0, headReady = '0, headSquashed = '0, headExecuted = '0;
  logic [W-1:0] headSerial = '0, headLoad = '0, headStore = '0, headFault = '0, headNop = '0;
  logic [W*SEQ_W-1:0] headSeq = '0;
  logic storesPending = 1'b0;
  logic [T-1:0] occChanged = '0, robEmpty = '0, trapAck = '0;
  logic [W-1:0] retireVec;
  logic [0:0] retireTid;
  logic [CNT_W-1:0] commitCnt;
  logic [2:0] stallCode;
  logic relValid, relUncached;
  logic [SEQ_W-1:0] relSeq;
  logic [T-1:0] trapReq, freeUpd, emptyRpt, storeFlag;
  logic [T*PC_W-1:0] pcOut;
  logic [FW-1:0] fullCnt;

  commit_head_unit #(.W(W), .THREADS(T), .SEQ_W(SEQ_W), .PC_W(PC_W),
                     .INST_BYTES(IB), .FULLCNT_W(FW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int kind[W];
  logic [W-1:0] eMask;
  int eUsed, eCnt, eStall, eSeq;
  bit eRel, eUnc, eTrap, eStore;
  int expPc[T];
  int expFull;
  bit [T-1:0] expPend;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kinds: 0 absent, 1 not ready, 2 squashed, 3 plain, 4 nop, 5 store,
  // 6 unexecuted serializing, 7 unexecuted load, 8 fault
  task automatic applyKinds();
    for (int j = 0; j < W; j++) begin
      headValid[j]    = kind[j] != 0;
      headReady[j]    = kind[j] >= 2;
      headSquashed[j] = kind[j] == 2;
      headExecuted[j] = kind[j] inside {2, 3, 4, 5, 8};
      headSerial[j]   = kind[j] == 6;
      headLoad[j]     = kind[j] == 7;
      headStore[j]    = kind[j] == 5;
      headFault[j]    = kind[j] == 8;
      headNop[j]      = kind[j] == 4;
      headSeq[j*SEQ_W +: SEQ_W] = SEQ_W'(8'h40 + j);
    end
  endtask

  task automatic model(input bit sp, input bit hold);
    bit stop;
    eMask = '0; eUsed = 0; eCnt = 0; eStall = 0; eSeq = 0;
    eRel = 0; eUnc = 0; eTrap = 0; eStore = 0;
    stop = hold;
    if (hold) eStall = 4;
    for (int j = 0; j < W; j++) begin
      if (!stop) begin
        case (kind[j])
          0, 1: begin stop = 1; eStall = 1; end
          2: eMask[j] = 1'b1;
          3, 4, 5: begin
            eMask[j] = 1'b1; eUsed++;
            if (kind[j] != 4) eCnt++;
            if (kind[j] == 5) eStore = 1;
          end
          6, 7: begin
            stop = 1;
            if (eUsed == 0 && !sp) begin eRel = 1; eUnc = kind[j] == 7; eSeq = 8'h40 + j; end
            else eStall = 2;
          end
          default: begin
            stop = 1;
            if (eUsed == 0 && !sp) eTrap = 1; else eStall = 3;
          end
        endcase
      end
    end
  endtask

  task automatic step(input int tid, input bit sel, input bit sp,
                      input logic [T-1:0] occ, input logic [T-1:0] emp,
                      input logic [T-1:0] ack, input logic [T-1:0] expRpt);
    bit hold;
    logic [T-1:0] eFree, eStoreV, eTrapV;
    @(negedge clk);
    selValid = sel; selTid = 1'(tid); storesPending = sp;
    occChanged = occ; robEmpty = emp; trapAck = ack;
    applyKinds();
    hold = sel && expPend[tid];
    if (sel) model(sp, hold);
    else begin
      eMask = '0; eUsed = 0; eCnt = 0; eStall = 0; eSeq = 0;
      eRel = 0; eUnc = 0; eTrap = 0; eStore = 0;
    end
    @(posedge clk); #1;
    eFree = occ; eStoreV = '0; eTrapV = '0;
    if (sel && eMask != '0) eFree[tid] = 1'b1;
    if (sel && eStore) eStoreV[tid] = 1'b1;
    if (sel && eTrap) eTrapV[tid] = 1'b1;
    if (sel) expPc[tid] = (expPc[tid] + eUsed * IB) % (1 << PC_W);
    if (eUsed == W && expFull < (1 << FW) - 1) expFull++;
    expPend = (expPend & ~ack) | eTrapV;
    chk(hold ? "R6 retire mask" : "R1 retire mask", 32'(retireVec), 32'(eMask));
    chk(hold ? "R6 stall code" : "R1 stall code", 32'(stallCode), 32'(eStall));
    if (sel) chk("R1 retire thread", 32'(retireTid), 32'(tid));
    chk("R8 commit count", 32'(commitCnt), 32'(eCnt));
    chk("R3 release valid", 32'(relValid), 32'(eRel));
    chk("R3 release seq", 32'(relSeq), 32'(eSeq));
    chk("R4 uncached flag", 32'(relUncached), 32'(eUnc));
    chk("R5 trap request", 32'(trapReq), 32'(eTrapV));
    chk("R11 free update", 32'(freeUpd), 32'(eFree));
    chk("R9 store flag", 32'(storeFlag), 32'(eStoreV));
    chk("R10 empty report", 32'(emptyRpt), 32'(expRpt));
    chk("R12 full count", 32'(fullCnt), 32'(expFull));
    for (int t = 0; t < T; t++)
      chk("R7 pc", 32'(pcOut[t*PC_W +: PC_W]), 32'(expPc[t]));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; selValid = 0; occChanged = '0; robEmpty = '0; trapAck = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expPc[0] = 0; expPc[1] = 0; expFull = 0; expPend = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    #1;
    chk("R1 reset retire", 32'(retireVec), 32'd0);
    chk("R7 reset pc", 32'(pcOut), 32'd0);
    chk("R12 reset count", 32'(fullCnt), 32'd0);
    // sweep of every window pattern with both store states
    for (int c = 0; c < 1458; c++) begin
      int tid;
      kind[0] = c % 9; kind[1] = (c / 9) % 9; kind[2] = (c / 81) % 9;
      tid = (c / 3) % 2;
      step(tid, 1, (c / 729) % 2 == 1, '0, '0, '0, '0);
      if (eTrap) begin
        kind[0] = 3; kind[1] = 3; kind[2] = 3;
        step(tid, 1, 0, '0, '0, 2'(1 << tid), '0);
        chk("R6 hold released", 32'(expPend), 32'd0);
      end
    end
    // squashed entries leave the first slot free
    kind[0] = 2; kind[1] = 6; kind[2] = 3;
    step(0, 1, 0, '0, '0, '0, '0);
    chk("R2 release after squashed", 32'(relValid), 32'd1);
    kind[0] = 2; kind[1] = 2; kind[2] = 8;
    step(1, 1, 0, '0, '0, '0, '0);
    chk("R2 trap after squashed", 32'(trapReq), 32'd2);
    kind[0] = 3; kind[1] = 3; kind[2] = 3;
    step(1, 1, 0, '0, '0, 2'b10, '0);
    chk("R6 held thread", 32'(stallCode), 32'd4);
    // empty reporting from a clean state
    doReset();
    kind[0] = 0; kind[1] = 0; kind[2] = 0;
    step(0, 0, 0, 2'b00, 2'b01, '0, 2'b00);
    step(0, 0, 1, 2'b01, 2'b01, '0, 2'b00);
    kind[0] = 5;
    step(0, 1, 0, 2'b00, 2'b01, '0, 2'b00);
    kind[0] = 0;
    step(0, 0, 0, 2'b00, 2'b01, '0, 2'b01);
    step(0, 0, 0, 2'b00, 2'b01, '0, 2'b00);
    chk("R9 store flag dropped", 32'(storeFlag), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule